// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is an eight-stage parallel-in, serial-out register. It turns a captured word into a bit stream. A mode pin chooses between capturing the word and shifting it. While the pin is low, every stage copies its own bit of the parallel word on each system clock. While the pin is high, the stages move one place toward the output end on each gated rising edge. A fill bit enters the first stage on each shift. The last stage drives a true output and an inverted output.

The shift clock is the OR of two gate pins, `gate_a` and `gate_b`, which play equal roles. A rise on either pin while the other is low gives one shift. Holding either pin high blocks the other. The block runs on a single fast system clock and samples both gate pins as ordinary synchronous inputs. A shift takes place in the system cycle in which the sampled OR goes from 0 to 1. The data pins are plain levels, not a valid/ready stream. The word is taken whenever the mode pin is low and is never refused, so there is no back-pressure.

Top module: `gated_shift_reg`

## Requirements
- R1: While `shift_mode` is 0, each system clock copies `word_in[i]` into stage i. Stage 0 is the first stage and stage 7 is the last, and `tail_q` shows `word_in[7]` after that edge. This happens whatever the levels of `gate_a`, `gate_b` and `fill_bit`.
- R2: While `shift_mode` is 1, `word_in` has no effect on the stages.
- R3: With `shift_mode` at 1 and `gate_b` at 0, a 0-to-1 change of `gate_a` between two consecutive system clock samples causes exactly one shift.
- R4: With `shift_mode` at 1 and `gate_a` at 0, a 0-to-1 change of `gate_b` causes exactly one shift.
- R5: While either gate pin is held at 1, toggling the other pin causes no shift.
- R6: On a shift, stage i takes the old value of stage i-1 and stage 0 takes `fill_bit`. After a load, successive shifts therefore present the loaded bits on `tail_q` in order 7, 6, … 0, followed by the fill bits.
- R7: `tail_qn` is always the inverse of `tail_q`.
- R8: If a gated rise and `shift_mode` at 0 fall in the same system cycle, the load takes effect and no shift is applied.
- R9: A synchronous active-high `rst` clears all stages, giving `tail_q` = 0 and `tail_qn` = 1.
- R10: A gate OR that stays at 1 for many cycles gives only one shift; the next shift needs the OR to return to 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_mode | input | 1 | 0 = capture `word_in`, 1 = shift on gated rise |
| gate_a | input | 1 | Gate pin, interchangeable with `gate_b` |
| gate_b | input | 1 | Gate pin, interchangeable with `gate_a` |
| fill_bit | input | 1 | Bit that enters stage 0 on a shift |
| word_in | input | STAGES | Parallel word; bit i goes to stage i |
| tail_q | output | 1 | Last stage, true form |
| tail_qn | output | 1 | Last stage, inverted form |

## Verification
Two functions can meet in one system cycle: a parallel capture and a gated rise. The bench provokes this by driving `shift_mode` low in the same cycle that `gate_a` first rises, with a new word whose top bit differs from what a shift would give. The result is judged on `tail_q` after that edge, which must show the new word's top bit. The cycle after, with the gate still high and the mode back to shift, `tail_q` must not move, because the rise was consumed by the load.

// File: rtl/gshift_pkg.sv
package gshift_pkg;
  localparam int unsigned GS_DEFAULT_STAGES = 8;

  // Operation applied to the stage array on a system clock edge
  typedef enum logic [1:0] {
    GS_HOLD  = 2'd0,
    GS_LOAD  = 2'd1,
    GS_SHIFT = 2'd2
  } gs_op_e;
endpackage

// File: rtl/gshift_gate_sense.sv
module gshift_gate_sense (
  input  logic clk,
  input  logic rst,
  input  logic gate_a,
  input  logic gate_b,
  output logic rise
);
  logic gate_or;
  logic gate_prev;

  assign gate_or = gate_a | gate_b;

  // Reset to 1 so a gate already high at reset release causes no shift
  always_ff @(posedge clk) begin
    if (rst) gate_prev <= 1'b1;
    else     gate_prev <= gate_or;
  end

  assign rise = gate_or & ~gate_prev;

  // A rise cannot repeat until the OR has dropped again
  p_single_rise_r10: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

  // A gate held high through two samples blocks any rise
  p_inhibit_a_r5: assert property (@(posedge clk) disable iff (rst)
    (gate_a && $past(gate_a)) |-> !rise);
  p_inhibit_b_r5: assert property (@(posedge clk) disable iff (rst)
    (gate_b && $past(gate_b)) |-> !rise);
endmodule

// File: rtl/gshift_ctrl.sv
module gshift_ctrl
  import gshift_pkg::*;
(
  input  logic   shift_mode,
  input  logic   rise,
  output gs_op_e op
);
  // Capture has priority over a gated rise in the same cycle
  always_comb begin
    if (!shift_mode) op = GS_LOAD;
    else if (rise)   op = GS_SHIFT;
    else             op = GS_HOLD;
  end
endmodule

// File: rtl/gshift_stages.sv
module gshift_stages
  import gshift_pkg::*;
#(
  parameter int unsigned STAGES = GS_DEFAULT_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  gs_op_e            op,
  input  logic [STAGES-1:0] word_in,
  input  logic              fill_bit,
  output logic [STAGES-1:0] stage_q
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic from_prev;
    if (i == 0) begin : g_head
      assign from_prev = fill_bit;
    end else begin : g_body
      assign from_prev = stage_q[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[i] <= 1'b0;
      end else begin
        case (op)
          GS_LOAD:  stage_q[i] <= word_in[i];
          GS_SHIFT: stage_q[i] <= from_prev;
          default:  stage_q[i] <= stage_q[i];
        endcase
      end
    end
  end

  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    (op == GS_LOAD) |=> (stage_q == $past(word_in)));

  p_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (op == GS_SHIFT) |=> (stage_q == {$past(stage_q[LAST-1:0]), $past(fill_bit)}));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (op == GS_HOLD) |=> $stable(stage_q));
endmodule

// File: rtl/gated_shift_reg.sv
module gated_shift_reg
  import gshift_pkg::*;
#(
  parameter int unsigned STAGES = GS_DEFAULT_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_mode,
  input  logic              gate_a,
  input  logic              gate_b,
  input  logic              fill_bit,
  input  logic [STAGES-1:0] word_in,
  output logic              tail_q,
  output logic              tail_qn
);
  localparam int unsigned LAST = STAGES - 1;

  logic              rise;
  gs_op_e            op;
  logic [STAGES-1:0] stage_q;

  gshift_gate_sense u_sense (
    .clk    (clk),
    .rst    (rst),
    .gate_a (gate_a),
    .gate_b (gate_b),
    .rise   (rise)
  );

  gshift_ctrl u_ctrl (
    .shift_mode (shift_mode),
    .rise       (rise),
    .op         (op)
  );

  gshift_stages #(.STAGES(STAGES)) u_stages (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .word_in  (word_in),
    .fill_bit (fill_bit),
    .stage_q  (stage_q)
  );

  assign tail_q  = stage_q[LAST];
  assign tail_qn = ~stage_q[LAST];

  // Capture wins over a simultaneous gated rise
  p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (!shift_mode && rise) |=> (tail_q == $past(word_in[LAST])));

  // A rise while in shift mode brings the next-to-last stage to the tail
  p_rise_moves_tail_r3: assert property (@(posedge clk) disable iff (rst)
    (shift_mode && rise) |=> (tail_q == $past(stage_q[LAST-1])));
endmodule

// File: tb/gated_shift_reg_tb.sv
`timescale 1ns/1ps
module gated_shift_reg_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       shift_mode;
  logic       gate_a;
  logic       gate_b;
  logic       fill_bit;
  logic [7:0] word_in;
  logic       tail_q;
  logic       tail_qn;

  always #2.5 clk = ~clk;

  gated_shift_reg #(.STAGES(8)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .shift_mode (shift_mode),
    .gate_a     (gate_a),
    .gate_b     (gate_b),
    .fill_bit   (fill_bit),
    .word_in    (word_in),
    .tail_q     (tail_q),
    .tail_qn    (tail_qn)
  );

  typedef struct {
    string tag;
    logic  q;
  } item_t;

  item_t      exp_q[$];
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;
  logic [7:0] model;
  logic       prev_or;

  // Driver: apply one cycle of inputs, predict the outcome, queue it
  task automatic op(input logic m, input logic ga, input logic gb,
                    input logic [7:0] w, input logic f, input string tag);
    logic now_or;
    logic up;
    @(negedge clk);
    shift_mode = m; gate_a = ga; gate_b = gb; word_in = w; fill_bit = f;
    now_or  = ga | gb;
    up      = now_or & ~prev_or;
    prev_or = now_or;
    if (!m)      model = w;
    else if (up) model = {model[6:0], f};
    @(posedge clk);
    #1;
    exp_q.push_back('{tag, model[7]});
  endtask

  // Monitor: compare one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (tail_q !== it.q) begin
          fails++;
          $display("FAIL %s tail_q actual=%b expected=%b", it.tag, tail_q, it.q);
        end
        checks++;
        if (tail_qn !== ~it.q) begin
          fails++;
          $display("FAIL R7 (%s) tail_qn actual=%b expected=%b", it.tag, tail_qn, ~it.q);
        end
      end
    end
  end

  initial begin
    logic [7:0] fills;
    rst = 1'b1; shift_mode = 1'b1; gate_a = 1'b0; gate_b = 1'b0;
    fill_bit = 1'b0; word_in = 8'h00;
    model = 8'h00; prev_or = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk); rst = 1'b0;
    exp_q.push_back('{"R9 reset", 1'b0});

    // R1: capture with gates idle
    op(1'b0, 1'b0, 1'b0, 8'hB4, 1'b0, "R1 load B4");
    // R2: word changes while in shift mode
    op(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R2 word ignored");
    op(1'b1, 1'b0, 1'b0, 8'h7F, 1'b1, "R2 word ignored");

    // R3/R6: eight rises on gate_a, fill pattern enters behind
    fills = 8'b0100_1101;
    for (int k = 0; k < 8; k++) begin
      op(1'b1, 1'b1, 1'b0, 8'h00, fills[k], "R3 R6 shift on gate_a rise");
      op(1'b1, 1'b0, 1'b0, 8'hFF, ~fills[k], "R10 no shift on fall");
    end
    // Fill bits now emerge
    for (int k = 0; k < 3; k++) begin
      op(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R6 fill bits emerge");
      op(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R6 idle");
    end

    // R5: gate_a held high blocks gate_b toggles
    op(1'b0, 1'b1, 1'b0, 8'h5A, 1'b1, "R1 load 5A with gate_a high");
    for (int k = 0; k < 3; k++) begin
      op(1'b1, 1'b1, 1'b1, 8'h00, 1'b1, "R5 gate_a held, gate_b up");
      op(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, "R5 gate_a held, gate_b down");
    end
    // R5: gate_b held high blocks gate_a toggles
    op(1'b1, 1'b1, 1'b1, 8'h00, 1'b1, "R5 both high");
    op(1'b1, 1'b0, 1'b1, 8'h00, 1'b1, "R5 gate_b held, gate_a down");
    op(1'b1, 1'b1, 1'b1, 8'h00, 1'b1, "R5 gate_b held, gate_a up");
    op(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R5 release");

    // R4: rises on gate_b with gate_a low
    for (int k = 0; k < 4; k++) begin
      op(1'b1, 1'b0, 1'b1, 8'h00, k[0], "R4 shift on gate_b rise");
      op(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R4 gate_b fall");
    end

    // R10: one long high gives a single shift
    op(1'b0, 1'b0, 1'b0, 8'hC3, 1'b0, "R1 load C3");
    for (int k = 0; k < 5; k++)
      op(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R10 long high, one shift");
    op(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R10 release");
    op(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R10 second shift");

    // R8: load and gated rise in the same cycle
    op(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R8 setup");
    op(1'b0, 1'b1, 1'b0, 8'h81, 1'b0, "R8 load wins over rise");
    op(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R8 rise consumed");
    op(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R8 still held");

    // R9: reset again from a non-zero state
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    exp_q.push_back('{"R9 reset clears", 1'b0});
    rst = 1'b0; prev_or = 1'b1; model = 8'h00; gate_a = 1'b0;
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // Watchdog
  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule